// File: doc/BRIEF.md
# SPI Serial Memory Slave Controller

This block is the slave-side serial front end of a 512-byte non-volatile memory. It watches a four-wire SPI link (chip select, serial clock, data in, data out) plus a hold input, all brought into a fast system clock. The first byte after chip select goes low is taken as a command. The block then streams array contents or the status byte out, collects write data and the status byte, or issues a write-enable set or clear strobe. The serial clock must run at least four times slower than the system clock.

Array contents come from a byte-wide read port that answers in the same cycle. Programming is left to outside units. The block sends them one-cycle strobes: one per received data byte, together with its target address, and a commit strobe when chip select rises cleanly at a byte boundary. The status value and the programming-busy flag come in from the status unit.

Top module: `spi_mem_slave`

## Requirements
- R1: While chip select is high, `so_oe` stays low and no strobe fires, whatever happens on `sck` and `si`.
- R2: The link runs in SPI mode 0 with MSB first. Data in is sampled on the rising edge of `sck`, and `so` changes only after a falling edge, so it holds steady while `sck` is high.
- R3: Command byte `0000_A011` starts a read. A (bit 3) is address bit 8, and the next byte gives address bits 7..0. On the falling edges after that, array bytes come out MSB first with `so_oe` high, and data-in bits are ignored.
- R4: During a read, the address steps by one after each byte and wraps from 0x1FF to 0x000.
- R5: Command 0x05 returns `status_in` on every following byte for as long as chip select stays low.
- R6: Command 0x06 pulses `wen_set` once, and command 0x04 pulses `wen_clr` once. At most one strobe fires in any cycle.
- R7: Command `0000_A010` followed by an address byte starts a write. Each complete data byte pulses `wr_req` with `wr_data` and `wr_addr`. The two low address bits count up and wrap inside a 4-byte group, while the upper bits stay fixed.
- R8: `wr_commit` pulses when chip select rises after at least one complete write data byte with no partial byte pending. Otherwise it does not pulse.
- R9: Command 0x01 followed by one byte pulses `sr_wr` once, with that byte on `sr_wdata`. Any further bytes are ignored.
- R10: After any other command byte, `so_oe` stays low and no strobe fires until chip select falls again. The next frame then works normally.
- R11: Holding `hold_n` low while `sck` is low drives `so_oe` low and freezes the transfer. Releasing it resumes the transfer with no bit lost.
- R12: While `busy` is high, only command 0x05 is acted on. Every other command produces no strobe and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | SPI data into the block |
| hold_n | input | 1 | Transfer suspend, active low |
| busy | input | 1 | A programming cycle is in progress |
| status_in | input | 8 | Status byte returned by command 0x05 |
| mem_rdata | input | 8 | Array byte at `mem_raddr`, same cycle |
| so | output | 1 | SPI data out of the block |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| mem_raddr | output | 9 | Array read address |
| wen_set | output | 1 | Set write enable, one-cycle strobe |
| wen_clr | output | 1 | Clear write enable, one-cycle strobe |
| sr_wr | output | 1 | Status write strobe |
| sr_wdata | output | 8 | Byte for the status write |
| wr_req | output | 1 | Write data byte strobe |
| wr_addr | output | 9 | Target address of the write byte |
| wr_data | output | 8 | Write data byte |
| wr_commit | output | 1 | Programming start strobe at chip select rise |

## Verification
A wrong bit count or a mis-stepped read address shows up at once on `so`. Every byte of a read stream is compared, so a fault is caught within the first 8 serial clocks of the byte it damages. A 514-byte stream from address 0 covers every array location and the wrap back to 0x000. A wrong decode shows up as a stray or missing strobe, or as `so_oe` rising when it should not. This is visible within one serial byte of the command. A counter that moves during a hold breaks the data byte that follows the hold.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPCODE, ST_ADDR, ST_RDATA, ST_WDATA, ST_STATUS, ST_IGNORE
  } st_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_WEN_SET, OP_WEN_CLR, OP_RDSTAT, OP_WRSTAT, OP_READ, OP_WRITE
  } op_e;

  // Command byte decode; while busy only the status read survives.
  function automatic op_e decode_op(input logic [7:0] b, input logic busy_i);
    op_e r;
    r = OP_NONE;
    if (b == 8'h05)                                 r = OP_RDSTAT;
    else if (busy_i)                                r = OP_NONE;
    else if (b == 8'h06)                            r = OP_WEN_SET;
    else if (b == 8'h04)                            r = OP_WEN_CLR;
    else if (b == 8'h01)                            r = OP_WRSTAT;
    else if (b[7:4] == 4'h0 && b[2:0] == 3'b011)    r = OP_READ;
    else if (b[7:4] == 4'h0 && b[2:0] == 3'b010)    r = OP_WRITE;
    return r;
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int         N       = 4,
  parameter int         STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         bit_o,
  output logic         valid
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; bit_o <= 1'b0; valid <= 1'b0;
    end else if (clear) begin
      sh <= '0; bit_o <= 1'b0; valid <= 1'b0;
    end else if (load) begin
      bit_o <= din[W-1];
      sh    <= {din[W-2:0], 1'b0};
      valid <= 1'b1;
    end else if (shift) begin
      bit_o <= sh[W-1];
      sh    <= {sh[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int AW          = 9,
  parameter int PAGE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          si,
  input  logic          hold_n,
  input  logic          busy,
  input  logic [7:0]    status_in,
  input  logic [7:0]    mem_rdata,
  output logic          so,
  output logic          so_oe,
  output logic [AW-1:0] mem_raddr,
  output logic          wen_set,
  output logic          wen_clr,
  output logic          sr_wr,
  output logic [7:0]    sr_wdata,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          wr_commit
);
  localparam int BW  = 8;
  localparam int BCW = $clog2(BW);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BW - 1);

  // Address arithmetic, kept in functions for restatement by the bench.
  function automatic logic [AW-1:0] stream_next(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [AW-1:0] page_next(input logic [AW-1:0] a);
    logic [PAGE_W-1:0] lo;
    lo = a[PAGE_W-1:0] + PAGE_W'(1);
    return {a[AW-1:PAGE_W], lo};
  endfunction

  // Pin synchronisation: {cs_n, sck, si, hold_n}
  logic [3:0] pins_s;
  spi_pin_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, si, hold_n}), .q(pins_s)
  );
  logic cs_s, sck_s, si_s, hold_s;
  assign {cs_s, sck_s, si_s, hold_s} = pins_s;

  logic sck_d, cs_d;
  st_e  state;
  logic [BCW-1:0] bit_cnt;
  logic [BW-1:0]  rx_sh;
  logic [AW-1:0]  rd_addr, wr_ptr;
  logic a_hi, rd_mode, sr_mode, got_byte;

  // Named internal events
  logic sel, held, rise_ev, fall_ev, byte_done, cs_rise, out_st;
  st_e  cur_st;
  logic [BW-1:0] rx_byte;
  op_e  op_dec;

  assign sel       = ~cs_s;
  assign held      = sel & ~hold_s;
  assign rise_ev   = sel & ~held & sck_s & ~sck_d;
  assign fall_ev   = sel & ~held & ~sck_s & sck_d;
  assign byte_done = rise_ev & (bit_cnt == LAST_BIT);
  assign cs_rise   = cs_s & ~cs_d;
  assign cur_st    = (state == ST_IDLE) ? ST_OPCODE : state;
  assign rx_byte   = {rx_sh[BW-2:0], si_s};
  assign op_dec    = decode_op(rx_byte, busy);
  assign out_st    = (cur_st == ST_RDATA) | ((cur_st == ST_STATUS) & ~sr_mode);
  assign mem_raddr = rd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0; cs_d <= 1'b1;
      state <= ST_IDLE; bit_cnt <= '0; rx_sh <= '0;
      rd_addr <= '0; wr_ptr <= '0;
      a_hi <= 1'b0; rd_mode <= 1'b0; sr_mode <= 1'b0; got_byte <= 1'b0;
      wen_set <= 1'b0; wen_clr <= 1'b0; sr_wr <= 1'b0; sr_wdata <= '0;
      wr_req <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_commit <= 1'b0;
    end else begin
      sck_d     <= sck_s;
      cs_d      <= cs_s;
      wen_set   <= 1'b0;
      wen_clr   <= 1'b0;
      sr_wr     <= 1'b0;
      wr_req    <= 1'b0;
      wr_commit <= cs_rise & (state == ST_WDATA) & (bit_cnt == '0) & got_byte;
      if (!sel) begin
        state    <= ST_IDLE;
        bit_cnt  <= '0;
        got_byte <= 1'b0;
        sr_mode  <= 1'b0;
      end else begin
        state <= cur_st;
        if (rise_ev) begin
          bit_cnt <= bit_cnt + BCW'(1);
          rx_sh   <= rx_byte;
        end
        if (byte_done) begin
          unique case (cur_st)
            ST_OPCODE: begin
              a_hi <= rx_byte[3];
              unique case (op_dec)
                OP_WEN_SET: begin wen_set <= 1'b1; state <= ST_IGNORE; end
                OP_WEN_CLR: begin wen_clr <= 1'b1; state <= ST_IGNORE; end
                OP_RDSTAT:  begin sr_mode <= 1'b0; state <= ST_STATUS; end
                OP_WRSTAT:  begin sr_mode <= 1'b1; state <= ST_STATUS; end
                OP_READ:    begin rd_mode <= 1'b1; state <= ST_ADDR; end
                OP_WRITE:   begin rd_mode <= 1'b0; state <= ST_ADDR; end
                default:    state <= ST_IGNORE;
              endcase
            end
            ST_ADDR: begin
              rd_addr <= AW'({a_hi, rx_byte});
              wr_ptr  <= AW'({a_hi, rx_byte});
              state   <= rd_mode ? ST_RDATA : ST_WDATA;
            end
            ST_RDATA: rd_addr <= stream_next(rd_addr);
            ST_WDATA: begin
              wr_req   <= 1'b1;
              wr_addr  <= wr_ptr;
              wr_data  <= rx_byte;
              wr_ptr   <= page_next(wr_ptr);
              got_byte <= 1'b1;
            end
            ST_STATUS: if (sr_mode) begin
              sr_wr    <= 1'b1;
              sr_wdata <= rx_byte;
              state    <= ST_IGNORE;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // Output path: a new byte is loaded on the first falling edge of each byte
  logic tx_valid;
  spi_tx_shifter #(.W(BW)) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(~sel),
    .load(fall_ev & out_st & (bit_cnt == '0)),
    .shift(fall_ev & out_st & (bit_cnt != '0)),
    .din((cur_st == ST_RDATA) ? mem_rdata : status_in),
    .bit_o(so), .valid(tx_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) so_oe <= 1'b0;
    else        so_oe <= sel & ~held & tx_valid & out_st;
  end
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk
  import spi_mem_pkg::*;
#(
  parameter int AW  = 9,
  parameter int BCW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel,
  input logic          held,
  input logic          byte_done,
  input logic          busy,
  input st_e           cur_st,
  input logic [BCW-1:0] bit_cnt,
  input logic          so_oe,
  input logic [AW-1:0] mem_raddr,
  input logic          wen_set,
  input logic          wen_clr,
  input logic          sr_wr,
  input logic          wr_req,
  input logic          wr_commit
);
  // R1
  cs_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !so_oe);
  // R11
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable(bit_cnt));
  // R10
  bad_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cur_st == ST_IGNORE) |=> !so_oe);
  // R6
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wen_set, wen_clr, sr_wr, wr_req, wr_commit}));
  // R4
  rd_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && cur_st == ST_RDATA) |=> mem_raddr == AW'($past(mem_raddr) + AW'(1)));
  // R12
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && cur_st == ST_OPCODE && busy) |=>
      (!sel || cur_st == ST_IGNORE || cur_st == ST_STATUS));
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.AW(AW), .BCW(BCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .held(held), .byte_done(byte_done),
  .busy(busy), .cur_st(cur_st), .bit_cnt(bit_cnt), .so_oe(so_oe),
  .mem_raddr(mem_raddr), .wen_set(wen_set), .wen_clr(wen_clr), .sr_wr(sr_wr),
  .wr_req(wr_req), .wr_commit(wr_commit)
);

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb;
  localparam int HALF = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, busy = 1'b0;
  logic [7:0] status_in = 8'h00;
  logic [7:0] mem_rdata;
  logic so, so_oe, wen_set, wen_clr, sr_wr, wr_req, wr_commit;
  logic [8:0] mem_raddr, wr_addr;
  logic [7:0] sr_wdata, wr_data;

  function automatic logic [7:0] mem_val(input logic [8:0] a);
    logic [7:0] v;
    v = a[7:0] * 8'd29 + 8'd7;
    return v ^ {a[8], 7'h00};
  endfunction

  assign mem_rdata = mem_val(mem_raddr);

  spi_mem_slave u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .busy(busy), .status_in(status_in), .mem_rdata(mem_rdata), .so(so), .so_oe(so_oe),
    .mem_raddr(mem_raddr), .wen_set(wen_set), .wen_clr(wen_clr), .sr_wr(sr_wr),
    .sr_wdata(sr_wdata), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit)
  );

  // Strobe monitor
  int n_set = 0, n_clr = 0, n_sr = 0, n_wr = 0, n_cm = 0;
  logic [7:0] sr_last = 8'h00;
  logic [8:0] wa_log [64];
  logic [7:0] wd_log [64];
  always @(posedge clk) begin
    if (wen_set) n_set = n_set + 1;
    if (wen_clr) n_clr = n_clr + 1;
    if (sr_wr) begin sr_last = sr_wdata; n_sr = n_sr + 1; end
    if (wr_commit) n_cm = n_cm + 1;
    if (wr_req) begin
      wa_log[n_wr % 64] = wr_addr;
      wd_log[n_wr % 64] = wr_data;
      n_wr = n_wr + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int hold_at, output logic [7:0] rx,
                      output logic oe_all, output logic oe_any, output logic hold_oe,
                      output logic steady);
    oe_all = 1'b1; oe_any = 1'b0; hold_oe = 1'b0; steady = 1'b1; rx = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      repeat (HALF) @(negedge clk);
      if (hold_at == i) begin
        hold_n = 1'b0;
        repeat (10) @(negedge clk);
        hold_oe = so_oe;
        hold_n = 1'b1;
        repeat (HALF) @(negedge clk);
      end
      rx[i] = so;
      oe_all = oe_all & so_oe;
      oe_any = oe_any | so_oe;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      if (so_oe && so !== rx[i]) steady = 1'b0;
      sck = 1'b0;
    end
  endtask

  task automatic frame_start();
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic frame_end();
    repeat (3) @(negedge clk); cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // Send a byte and report whether SO was ever driven
  task automatic put(input logic [7:0] b, output logic any);
    logic [7:0] r; logic a, h, s;
    xfer(b, -1, r, a, any, h, s);
  endtask

  task automatic read_run(input logic [8:0] start, input int nbytes, input int hold_byte,
                          input string req);
    logic [7:0] r; logic a, any, h, s, steady_all;
    steady_all = 1'b1;
    frame_start();
    put({4'h0, start[8], 3'b011}, any);
    chk("R3 opcode byte quiet", any, 0);
    put(start[7:0], any);
    chk("R3 address byte quiet", any, 0);
    for (int k = 0; k < nbytes; k++) begin
      xfer(8'(k * 13), (k == hold_byte) ? 4 : -1, r, a, any, h, s);
      chk(req, r, mem_val(start + 9'(k)));
      chk({req, " so_oe"}, a, 1);
      if (k == hold_byte) chk("R11 so_oe low in hold", h, 0);
      steady_all = steady_all & s;
    end
    chk("R2 so steady while sck high", steady_all, 1);
    frame_end();
  endtask

  initial begin
    logic any; logic [7:0] r; logic a, h, s;
    int b_set, b_clr, b_sr, b_wr, b_cm;

    repeat (5) @(negedge clk);
    chk("R1 reset so_oe", so_oe, 0);
    chk("R1 reset strobes", {wen_set, wen_clr, sr_wr, wr_req, wr_commit}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: activity while deselected
    b_set = n_set; b_clr = n_clr; b_sr = n_sr; b_wr = n_wr; b_cm = n_cm;
    any = 1'b0;
    for (int i = 0; i < 24; i++) begin
      si = i[0] ^ i[2];
      repeat (HALF) @(negedge clk); sck = 1'b1; any = any | so_oe;
      repeat (HALF) @(negedge clk); sck = 1'b0; any = any | so_oe;
    end
    chk("R1 so_oe while deselected", any, 0);
    chk("R1 no strobes while deselected", (n_set-b_set)+(n_clr-b_clr)+(n_sr-b_sr)+(n_wr-b_wr)+(n_cm-b_cm), 0);

    // R3/R4: whole array in one frame, plus wrap
    read_run(9'h000, 514, -1, "R4 full stream");
    read_run(9'h1FE, 4, -1, "R4 wrap 1FF->000");
    read_run(9'h0A5, 3, -1, "R3 read low half");
    read_run(9'h1C3, 3, -1, "R3 read A8 set");

    // R5: status read repeats
    status_in = 8'h5A;
    frame_start();
    put(8'h05, any);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, -1, r, a, any, h, s);
      chk("R5 status byte", r, 8'h5A);
      chk("R5 so_oe", a, 1);
    end
    frame_end();

    // R6: write enable set/clear
    b_set = n_set; b_clr = n_clr;
    frame_start(); put(8'h06, any); put(8'hFF, any); frame_end();
    chk("R6 wen_set once", n_set - b_set, 1);
    chk("R6 wen_set so quiet", any, 0);
    frame_start(); put(8'h04, any); frame_end();
    chk("R6 wen_clr once", n_clr - b_clr, 1);
    chk("R6 no extra set", n_set - b_set, 1);

    // R7/R8: write 5 bytes at 0x17E, group wrap
    b_wr = n_wr; b_cm = n_cm;
    frame_start();
    put(8'h0A, any); put(8'h7E, any);
    for (int k = 0; k < 5; k++) put(8'h30 + 8'(k), any);
    frame_end();
    chk("R7 write byte count", n_wr - b_wr, 5);
    for (int k = 0; k < 5; k++) begin
      chk("R7 write addr", wa_log[(b_wr + k) % 64], {7'b1011111, 2'(2 + k)});
      chk("R7 write data", wd_log[(b_wr + k) % 64], 8'h30 + 8'(k));
    end
    chk("R8 commit on clean end", n_cm - b_cm, 1);

    // R8: partial byte before deselect, no commit
    b_wr = n_wr; b_cm = n_cm;
    frame_start();
    put(8'h02, any); put(8'h10, any); put(8'hC7, any);
    si = 1'b1;
    for (int i = 0; i < 3; i++) begin
      repeat (HALF) @(negedge clk); sck = 1'b1;
      repeat (HALF) @(negedge clk); sck = 1'b0;
    end
    frame_end();
    chk("R8 byte before partial", n_wr - b_wr, 1);
    chk("R7 addr without A8", wa_log[b_wr % 64], 9'h010);
    chk("R8 no commit on partial", n_cm - b_cm, 0);

    // R8: write opcode with no data byte, no commit
    b_cm = n_cm;
    frame_start(); put(8'h02, any); put(8'h20, any); frame_end();
    chk("R8 no commit without data", n_cm - b_cm, 0);

    // R9: status write
    b_sr = n_sr;
    frame_start(); put(8'h01, any); put(8'h0C, any); put(8'hF3, any); frame_end();
    chk("R9 sr_wr once", n_sr - b_sr, 1);
    chk("R9 sr data", sr_last, 8'h0C);

    // R10: invalid opcodes
    b_set = n_set; b_clr = n_clr; b_sr = n_sr; b_wr = n_wr; b_cm = n_cm;
    frame_start();
    put(8'h0F, any);
    put(8'h03, a); any = any | a;
    put(8'h06, a); any = any | a;
    frame_end();
    chk("R10 so quiet after bad op", any, 0);
    frame_start(); put(8'hA3, any); put(8'h00, a); any = any | a; frame_end();
    chk("R10 upper nibble set quiet", any, 0);
    chk("R10 no strobes", (n_set-b_set)+(n_clr-b_clr)+(n_sr-b_sr)+(n_wr-b_wr)+(n_cm-b_cm), 0);
    read_run(9'h033, 2, -1, "R10 read after bad op");

    // R12: busy gating
    busy = 1'b1;
    b_set = n_set; b_wr = n_wr; b_sr = n_sr;
    frame_start(); put(8'h02, any); put(8'h00, any); put(8'h55, any); frame_end();
    frame_start(); put(8'h06, any); frame_end();
    frame_start(); put(8'h01, any); put(8'h08, any); frame_end();
    chk("R12 no strobes while busy", (n_set-b_set)+(n_wr-b_wr)+(n_sr-b_sr), 0);
    frame_start(); put(8'h03, any); put(8'h10, a); any = any | a; put(8'h00, a); any = any | a; frame_end();
    chk("R12 read blocked while busy", any, 0);
    status_in = 8'h81;
    frame_start(); put(8'h05, any); xfer(8'h00, -1, r, a, any, h, s); frame_end();
    chk("R12 status read while busy", r, 8'h81);
    busy = 1'b0;

    // R11: hold in mid byte
    read_run(9'h040, 3, 1, "R11 data across hold");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule